// File: doc/BRIEF.md
# Network configuration step sequencer

This controller sits between the operating system and every optical network interface manager on the chip, and there is only one of it. When the operating system picks a configuration mode to suit the running application, the sequencer latches that mode number and broadcasts it to all interface managers. It then runs the mode one step at a time. For each step it raises a one-cycle start pulse and then waits until every interface has reported that its part of the step is finished. Only after that does it launch the next step. When the last step is over it goes idle.

A mode request that arrives while a sequence is running does not disturb the broadcast mode. It is parked and applied as soon as the running sequence ends, and a later request overwrites an earlier parked one. Two programmable inputs shape each run. One gives the number of steps per mode. The other gives a cycle limit: an interface that stays silent longer than this limit aborts the sequence and raises a timeout flag.

Top module: `cfg_step_sequencer`

## Requirements
- R1: While reset is applied and afterwards with no request, `busy`, `start`, `timeout` are 0 and `mode_out` is 0.
- R2: A request (`req_valid` high for one cycle) sampled while idle makes `start` high, `busy` high and `mode_out` equal to `req_mode` in the following cycle.
- R3: `start` is never high in two consecutive cycles.
- R4: A step is complete once every interface has pulsed its `if_done` bit at least once since the step's start. The pulses may come in different cycles. The next `start` appears two cycles after the cycle in which the last missing done bit is sampled. Before that, `start` stays low.
- R5: `if_done` bits that are high in the same cycle as `start` do not count toward the step just started.
- R6: `step_count` is sampled when a request is accepted, and a value of 0 counts as 1. The sequence issues exactly that many start pulses. `busy` falls two cycles after the final step's last done bit is sampled. A sequence never ends in the cycle right after a start pulse.
- R7: `mode_out` holds constant while `busy` is high. A request made during a sequence is held pending, with the most recent one winning. The pending request is accepted in the first idle cycle, so its `start` comes one cycle after `busy` falls.
- R8: With `wd_limit` = L > 0, if the step is not complete by its L-th waiting cycle (the first waiting cycle is the one after `start`), the sequencer returns to idle in the next cycle with `timeout` high. `timeout` stays high until the next request is accepted. L = 0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode request strobe from the operating system |
| req_mode | input | MODE_W = clog2(N_MODES) | Requested mode number |
| step_count | input | STEP_W | Steps per mode, sampled at acceptance (0 treated as 1) |
| wd_limit | input | WD_W | Watchdog limit in waiting cycles, 0 disables |
| if_done | input | N_IF | Per-interface step-over pulses |
| mode_out | output | MODE_W | Mode number broadcast to all interfaces |
| start | output | 1 | One-cycle pulse that begins the current step |
| busy | output | 1 | High while a sequence runs |
| timeout | output | 1 | Set when a sequence is aborted by the watchdog |

## Verification
Every result is tied to a fixed cycle count:
- `start` and the new mode appear one cycle after an accepted request.
- The next `start` appears two cycles after the last done bit is sampled.
- `busy` falls two cycles after the final step's last done bit is sampled.
- A pending request starts one cycle after `busy` falls.
- The abort arrives one cycle after the L-th waiting cycle.

The bench drives inputs on falling edges and checks each output at the exact falling edge where it is due. It also checks the intervening cycles to confirm that no early `start` or early exit occurs. Random done delays, step counts and modes from a seeded `$urandom` are mixed with directed cases: done bits in the start cycle, two stacked pending requests, a step count of zero, and a watchdog that is disabled and then armed.

// File: rtl/cfg_step_sequencer.sv
module cfg_step_sequencer #(
  parameter int N_IF    = 4,
  parameter int N_MODES = 8,
  parameter int STEP_W  = 4,
  parameter int WD_W    = 12,
  localparam int MODE_W = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [STEP_W-1:0] step_count,
  input  logic [WD_W-1:0]   wd_limit,
  input  logic [N_IF-1:0]   if_done,
  output logic [MODE_W-1:0] mode_out,
  output logic              start,
  output logic              busy,
  output logic              timeout
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_NEXT} state_t;

  state_t            state;
  logic [N_IF-1:0]   done_q;
  logic [STEP_W-1:0] steps_q, step_idx;
  logic [WD_W-1:0]   wd_cnt;
  logic [MODE_W-1:0] mode_q, pend_mode;
  logic              pend_q, timeout_q;

  wire [N_IF-1:0]   done_seen = done_q | if_done;
  wire              all_done  = &done_seen;
  wire              accept    = (state == S_IDLE) && (req_valid || pend_q);
  wire [MODE_W-1:0] acc_mode  = req_valid ? req_mode : pend_mode;
  wire [WD_W:0]     wd_next   = {1'b0, wd_cnt} + {{WD_W{1'b0}}, 1'b1};
  wire              wd_fire   = (wd_limit != '0) && !all_done &&
                                (wd_next == {1'b0, wd_limit});
  wire              last_step = (step_idx == steps_q - STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done_q    <= '0;
      steps_q   <= STEP_W'(1);
      step_idx  <= '0;
      wd_cnt    <= '0;
      mode_q    <= '0;
      timeout_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          mode_q    <= acc_mode;
          steps_q   <= (step_count == '0) ? STEP_W'(1) : step_count;
          step_idx  <= '0;
          timeout_q <= 1'b0;
          state     <= S_START;
        end
        S_START: begin
          done_q <= '0;
          wd_cnt <= '0;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          done_q <= done_seen;
          wd_cnt <= wd_next[WD_W-1:0];
          if (all_done) state <= S_NEXT;
          else if (wd_fire) begin
            state     <= S_IDLE;
            timeout_q <= 1'b1;
          end
        end
        default: begin
          if (last_step) state <= S_IDLE;
          else begin
            step_idx <= step_idx + STEP_W'(1);
            state    <= S_START;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_mode <= '0;
    end else if (state != S_IDLE && req_valid) begin
      pend_q    <= 1'b1;
      pend_mode <= req_mode;
    end else if (accept) begin
      pend_q    <= 1'b0;
    end
  end

  assign mode_out = mode_q;
  assign start    = (state == S_START);
  assign busy     = (state != S_IDLE);
  assign timeout  = timeout_q;

endmodule

// File: rtl/cfg_step_sequencer_chk.sv
module cfg_step_sequencer_chk #(
  parameter int N_MODES = 8,
  localparam int MODE_W = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              timeout,
  input logic [MODE_W-1:0] mode_out
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start); // R3
  AST_START_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) start |-> busy); // R2
  AST_MODE_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(mode_out)); // R7
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> !busy); // R8
  AST_END_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !$past(start)); // R6

endmodule

bind cfg_step_sequencer cfg_step_sequencer_chk #(.N_MODES(N_MODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .timeout(timeout), .mode_out(mode_out)
);

// File: tb/cfg_step_sequencer_bench.sv
module cfg_step_sequencer_bench;
  localparam int N_IF = 4, N_MODES = 8, STEP_W = 4, WD_W = 12, MODE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [MODE_W-1:0] req_mode = '0;
  logic [STEP_W-1:0] step_count = '0;
  logic [WD_W-1:0]   wd_limit = '0;
  logic [N_IF-1:0]   if_done = '0;
  logic [MODE_W-1:0] mode_out;
  logic start, busy, timeout;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_step_sequencer #(.N_IF(N_IF), .N_MODES(N_MODES), .STEP_W(STEP_W), .WD_W(WD_W)) u_cfg_step_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .step_count(step_count), .wd_limit(wd_limit), .if_done(if_done),
    .mode_out(mode_out), .start(start), .busy(busy), .timeout(timeout));

  function automatic int exp_steps(input int prog);
    return (prog == 0) ? 1 : prog;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic request(input int mode, input int steps);
    req_valid = 1'b1; req_mode = 3'(mode); step_count = 4'(steps);
    @(negedge clk);
    req_valid = 1'b0;
    chk(start == 1'b1 && busy == 1'b1, "R2 start/busy", {start, busy}, 3);
    chk(mode_out == 3'(mode), "R2 mode", mode_out, mode);
  endtask

  task automatic do_step(input bit last, input int mode, input bit early, input int hold,
                         input int n_inj, input int m0, input int m1);
    int d [N_IF];
    int maxd;
    if (early) if_done = '1;
    @(negedge clk);
    if_done = '0;
    for (int h = 0; h < hold; h++) begin
      if (h < n_inj) begin req_valid = 1'b1; req_mode = 3'((h == 0) ? m0 : m1); end
      else req_valid = 1'b0;
      chk(start == 1'b0 && busy == 1'b1, early ? "R5 early done ignored" : "R4 hold", {start, busy}, 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    maxd = 0;
    for (int i = 0; i < N_IF; i++) begin
      d[i] = int'($urandom % 4);
      if (d[i] > maxd) maxd = d[i];
    end
    for (int t = 0; t <= maxd; t++) begin
      for (int i = 0; i < N_IF; i++) if_done[i] = (d[i] == t);
      chk(start == 1'b0, "R4 no early start", start, 0);
      @(negedge clk);
    end
    if_done = '0;
    chk(start == 1'b0 && busy == 1'b1, "R4 barrier gap", {start, busy}, 1);
    @(negedge clk);
    if (last) chk(busy == 1'b0 && start == 1'b0, "R6 end", {start, busy}, 0);
    else begin
      chk(start == 1'b1, "R4 next start", start, 1);
      chk(mode_out == 3'(mode), "R7 mode held", mode_out, mode);
    end
  endtask

  task automatic run_body(input int mode, input int prog, input bit early);
    int n;
    n = exp_steps(prog);
    for (int s = 0; s < n; s++) do_step(s == n - 1, mode, early && s == 0, early ? 2 : 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(busy == 0 && start == 0 && timeout == 0 && mode_out == 0, "R1 in reset",
        {busy, start, timeout}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && start == 0 && timeout == 0 && mode_out == 0, "R1 idle",
        {busy, start, timeout}, 0);

    request(5, 3); run_body(5, 3, 1'b1);
    request(3, 0); run_body(3, 0, 1'b0);
    request(7, 1); run_body(7, 1, 1'b1);

    request(2, 2);
    do_step(1'b0, 2, 1'b0, 3, 2, 5, 6);
    do_step(1'b1, 2, 1'b0, 0, 0, 0, 0);
    @(negedge clk);
    chk(start == 1'b1, "R7 pending start", start, 1);
    chk(mode_out == 3'd6, "R7 latest pending wins", mode_out, 6);
    run_body(6, 2, 1'b0);

    wd_limit = 12'd5;
    request(4, 3);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1 && timeout == 1'b0, "R8 before limit", {busy, timeout}, 2);
    @(negedge clk);
    chk(busy == 1'b0 && timeout == 1'b1, "R8 abort", {busy, timeout}, 1);
    @(negedge clk);
    chk(timeout == 1'b1 && start == 1'b0, "R8 flag held", timeout, 1);
    wd_limit = 12'd0;
    request(1, 1);
    chk(timeout == 1'b0, "R8 cleared", timeout, 0);
    do_step(1'b1, 1, 1'b0, 20, 0, 0, 0);

    for (int k = 0; k < 25; k++) begin
      int m, s;
      m = int'($urandom % N_MODES);
      s = int'($urandom % 5);
      request(m, s);
      run_body(m, s, bit'($urandom % 2));
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule